// File: doc/BRIEF.md
# Gated Serial Receive Engine

This block receives asynchronous serial characters on a single input line. While nothing is arriving, its bit timer is held at zero and produces no sample strobes. A falling edge on the synchronized line starts a low-run counter. Only a low level that lasts for the selected filter length wakes the bit timer, and the timer is loaded so that its count stays aligned to the first low clock. The start bit is then confirmed by a vote of three samples around the middle of the bit. If the vote reads high, the engine drops the attempt and stops the timer again. If it reads low, eight data bits and one stop bit are collected.

In the optional idle-line mode, the engine does not stop after the stop bit. It keeps timing bits on the same grid and counts consecutive high bits. Ten of them raise a sticky idle flag and put the engine back to rest. A new start bit that arrives before the tenth high bit begins the next character instead. A synchronous soft reset aborts any reception in progress and clears the flag.

The bit period is `baud_div` clocks and must be at least twice the selected filter length plus four, so that the start-bit samples fall after the wake-up point.

Top module: `serial_rx_engine`

## Requirements
- R1: While `rst_n` is low and right after it, `rx_valid` is 0, `idle_flag` is 0 and `rx_data` is 0.
- R2: The line passes through two flops before filtering. A low run on it shorter than the filter length is ignored and produces no character. The filter length is 2, 4, 8 or 16 clocks for `glitch_sel` = 0, 1, 2 or 3.
- R3: A low run of at least the filter length wakes the bit timer. If the vote on the start bit reads high, reception is abandoned, the timer stops, and a later frame is received with normal timing.
- R4: A frame is one low start bit, then 8 data bits least significant first, then one high stop bit, each `baud_div` = N clocks long. `rx_data` holds the 8 data bits.
- R5: `rx_valid` is high for exactly one clock per frame. That clock comes 9N + floor(N/2) + 3 clocks after the clock on which `rx_in` is first driven low for the start bit.
- R6: Every bit is decided by a majority of samples taken at bit counts h-1, h and h+1, where h = floor(N/2). One wrong sample at count h does not change any data bit.
- R7: With `idle_mode` = 1, ten consecutive high bit decisions after the stop bit set `idle_flag`. It rises 19N + h + 3 clocks after the start of the last frame.
- R8: With `idle_mode` = 1, a start bit that arrives after nine or fewer high bits begins the next character, and `idle_flag` stays low.
- R9: `idle_flag` stays set until a start bit is accepted. It then falls h + 3 clocks after that start bit begins. With `idle_mode` = 0, it never rises.
- R10: A one-clock `sw_rst` clears `idle_flag` and abandons the frame in progress, so that frame produces no `rx_valid`. The next frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous soft reset: go to rest, clear idle flag |
| rx_in | input | 1 | Asynchronous serial line, high when idle |
| glitch_sel | input | 2 | Start filter length select (2 << value clocks) |
| idle_mode | input | 1 | 1 enables idle-line monitoring after each character |
| baud_div | input | DIV_W (12) | Clocks per bit |
| rx_data | output | DATA_BITS (8) | Last received character |
| rx_valid | output | 1 | One-clock strobe when `rx_data` is updated |
| idle_flag | output | 1 | Sticky flag for ten idle bits in idle-line mode |

## Verification
The bench builds the engine with its default parameters: 8 data bits, a ten-bit idle count, a 12-bit divisor, a two-flop synchronizer and the three-sample vote. With divisors of 8 and 9, every byte value is cheap enough to send, so the full 256-value sweep is run along with a second pass at an odd bit length. A divisor of 40 lets all four filter lengths be tested at exactly one clock short of, and exactly at, their threshold. The idle-line cases use a divisor of 16, where the nine-versus-ten high-bit boundary and the clear-on-start timing are checked to the exact clock.

// File: rtl/rxe_pkg.sv
package rxe_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_WATCH
   } rx_state_e;

   // width of a counter that must hold the longest filter length (base << 3)
   function automatic int low_width(input int base);
      return $clog2((base << 3) + 1);
   endfunction

endpackage

// File: rtl/rxe_front.sv
module rxe_front #(
   parameter int SYNC_STAGES = 2,
   parameter int GLITCH_BASE = 2,
   parameter int LOW_W       = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_in,
   input  logic [1:0]       glitch_sel,
   output logic             rx_s,
   output logic [LOW_W-1:0] glitch_len,
   output logic             edge_hit
);

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("rxe_front: SYNC_STAGES must be at least 1");
   end
   if (GLITCH_BASE < 2) begin : g_bad_base
      $error("rxe_front: GLITCH_BASE must be at least 2");
   end
   if ((GLITCH_BASE << 3) >= (1 << LOW_W)) begin : g_bad_loww
      $error("rxe_front: LOW_W too narrow for the longest filter length");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [LOW_W-1:0]       low_q;
   logic [LOW_W-1:0]       len_m1;

   if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= rx_in;
      end
   end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
      end
   end

   assign rx_s = sync_q[SYNC_STAGES-1];

   // consecutive low clocks seen so far on the synchronized line
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q <= '0;
      end else if (!rx_s) begin
         if (low_q != '1) low_q <= low_q + 1'b1;
      end else begin
         low_q <= '0;
      end
   end

   assign glitch_len = LOW_W'(GLITCH_BASE) << glitch_sel;
   assign len_m1     = glitch_len - LOW_W'(1);
   assign edge_hit   = !rx_s && (low_q == len_m1);

   // R2
   filter_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |-> ($past(rx_s) == 1'b0));

endmodule

// File: rtl/rxe_bitgen.sv
module rxe_bitgen #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic [DIV_W-1:0] load_val,
   input  logic [DIV_W-1:0] div,
   output logic [DIV_W-1:0] cnt,
   output logic             tap_early,
   output logic             tap_mid,
   output logic             tap_late
);

   if (DIV_W < 4) begin : g_bad_div
      $error("rxe_bitgen: DIV_W must be at least 4");
   end

   logic [DIV_W-1:0] half;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (load)               cnt <= load_val;
      else if (!run)               cnt <= '0;
      else if (cnt >= div - 1'b1)  cnt <= '0;
      else                         cnt <= cnt + 1'b1;
   end

   assign half      = div >> 1;
   assign tap_early = run && (cnt == half - 1'b1);
   assign tap_mid   = run && (cnt == half);
   assign tap_late  = run && (cnt == half + 1'b1);

endmodule

// File: rtl/rxe_vote.sv
module rxe_vote #(
   parameter int VOTE_SAMPLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_s,
   input  logic tap_early,
   input  logic tap_mid,
   input  logic tap_late,
   output logic bit_val,
   output logic bit_ready
);

   if (VOTE_SAMPLES != 1 && VOTE_SAMPLES != 3) begin : g_bad_vote
      $error("rxe_vote: VOTE_SAMPLES must be 1 or 3");
   end

   logic mid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mid_q <= 1'b1;
      else if (tap_mid) mid_q <= rx_s;
   end

   if (VOTE_SAMPLES == 3) begin : g_maj
      logic early_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         early_q <= 1'b1;
         else if (tap_early) early_q <= rx_s;
      end
      assign bit_val = (early_q & mid_q) | (early_q & rx_s) | (mid_q & rx_s);

      // R6
      vote_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tap_late && (early_q == mid_q)) |-> (bit_val == mid_q));
   end else begin : g_single
      assign bit_val = mid_q;
   end

   assign bit_ready = tap_late;

endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
   import rxe_pkg::*;
#(
   parameter int DATA_BITS    = 8,
   parameter int IDLE_BITS    = 10,
   parameter int DIV_W        = 12,
   parameter int GLITCH_BASE  = 2,
   parameter int SYNC_STAGES  = 2,
   parameter int VOTE_SAMPLES = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sw_rst,
   input  logic                 rx_in,
   input  logic [1:0]           glitch_sel,
   input  logic                 idle_mode,
   input  logic [DIV_W-1:0]     baud_div,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_valid,
   output logic                 idle_flag
);

   localparam int LOW_W  = low_width(GLITCH_BASE);
   localparam int IDX_W  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
   localparam int ONES_W = $clog2(IDLE_BITS + 1);

   if (DATA_BITS < 1) begin : g_bad_data
      $error("serial_rx_engine: DATA_BITS must be at least 1");
   end
   if (IDLE_BITS < 1) begin : g_bad_idle
      $error("serial_rx_engine: IDLE_BITS must be at least 1");
   end
   if (DIV_W < LOW_W + 2) begin : g_bad_divw
      $error("serial_rx_engine: DIV_W too narrow for the filter length");
   end

   rx_state_e            state_q;
   logic                 rx_s;
   logic [LOW_W-1:0]     glitch_len;
   logic                 edge_hit;
   logic                 run;
   logic                 load;
   logic [DIV_W-1:0]     bit_cnt;
   logic                 tap_early, tap_mid, tap_late;
   logic                 bit_val, bit_ready;
   logic [DATA_BITS-1:0] shreg;
   logic [DATA_BITS:0]   shift_next;
   logic [IDX_W-1:0]     idx_q;
   logic [ONES_W-1:0]    ones_q;

   rxe_front #(
      .SYNC_STAGES (SYNC_STAGES),
      .GLITCH_BASE (GLITCH_BASE),
      .LOW_W       (LOW_W)
   ) u_front (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_in      (rx_in),
      .glitch_sel (glitch_sel),
      .rx_s       (rx_s),
      .glitch_len (glitch_len),
      .edge_hit   (edge_hit)
   );

   assign run  = (state_q != RX_IDLE);
   assign load = edge_hit && !sw_rst &&
                 ((state_q == RX_IDLE) || (state_q == RX_WATCH));

   rxe_bitgen #(
      .DIV_W (DIV_W)
   ) u_bitgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .load      (load),
      .load_val  (DIV_W'(glitch_len)),
      .div       (baud_div),
      .cnt       (bit_cnt),
      .tap_early (tap_early),
      .tap_mid   (tap_mid),
      .tap_late  (tap_late)
   );

   rxe_vote #(
      .VOTE_SAMPLES (VOTE_SAMPLES)
   ) u_vote (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_s      (rx_s),
      .tap_early (tap_early),
      .tap_mid   (tap_mid),
      .tap_late  (tap_late),
      .bit_val   (bit_val),
      .bit_ready (bit_ready)
   );

   assign shift_next = {bit_val, shreg};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= RX_IDLE;
         rx_data   <= '0;
         rx_valid  <= 1'b0;
         idle_flag <= 1'b0;
         shreg     <= '0;
         idx_q     <= '0;
         ones_q    <= '0;
      end else begin
         rx_valid <= 1'b0;
         if (sw_rst) begin
            state_q   <= RX_IDLE;
            idle_flag <= 1'b0;
         end else begin
            unique case (state_q)
               RX_IDLE: begin
                  if (edge_hit) state_q <= RX_START;
               end
               RX_START: begin
                  if (bit_ready) begin
                     if (!bit_val) begin
                        state_q   <= RX_DATA;
                        idx_q     <= '0;
                        idle_flag <= 1'b0;
                     end else begin
                        state_q <= RX_IDLE;
                     end
                  end
               end
               RX_DATA: begin
                  if (bit_ready) begin
                     shreg <= shift_next[DATA_BITS:1];
                     if (idx_q == IDX_W'(DATA_BITS - 1)) state_q <= RX_STOP;
                     else                                idx_q   <= idx_q + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (bit_ready) begin
                     rx_data  <= shreg;
                     rx_valid <= 1'b1;
                     ones_q   <= '0;
                     state_q  <= idle_mode ? RX_WATCH : RX_IDLE;
                  end
               end
               RX_WATCH: begin
                  if (edge_hit) begin
                     state_q <= RX_START;
                  end else if (bit_ready) begin
                     if (!bit_val) begin
                        ones_q <= '0;
                     end else if (ones_q == ONES_W'(IDLE_BITS - 1)) begin
                        idle_flag <= 1'b1;
                        state_q   <= RX_IDLE;
                     end else begin
                        ones_q <= ones_q + 1'b1;
                     end
                  end
               end
               default: state_q <= RX_IDLE;
            endcase
         end
      end
   end

   // R5
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R4
   valid_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> ($past(state_q) == RX_STOP));

   // R3
   timer_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == RX_IDLE) && ($past(state_q) == RX_IDLE)) |-> (bit_cnt == '0));

   // R7
   flag_from_watch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle_flag) |-> ($past(state_q) == RX_WATCH));

   // R9
   flag_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(idle_flag) |-> ($past(sw_rst) || ($past(state_q) == RX_START)));

   // R10
   soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> ((state_q == RX_IDLE) && !idle_flag && !rx_valid));

endmodule

// File: tb/serial_rx_engine_bench.sv
module serial_rx_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_rst = 1'b0;
   logic        rx_in = 1'b1;
   logic [1:0]  glitch_sel = 2'd0;
   logic        idle_mode = 1'b0;
   logic [11:0] baud_div = 12'd8;
   logic [7:0]  rx_data;
   logic        rx_valid;
   logic        idle_flag;

   int checks = 0;
   int errors = 0;
   int tpos = 0;
   int nvalid = 0;
   int vpos = -1;
   int rise_pos = -1;
   int fall_pos = -1;
   int nrise = 0;
   logic [7:0] vdata = 8'h00;
   logic flag_prev = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   serial_rx_engine u_serial_rx_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_rst     (sw_rst),
      .rx_in      (rx_in),
      .glitch_sel (glitch_sel),
      .idle_mode  (idle_mode),
      .baud_div   (baud_div),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .idle_flag  (idle_flag)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive one line value for one clock and observe outputs at the falling edge
   task automatic step(input logic v);
      rx_in = v;
      @(negedge clk);
      if (rx_valid) begin
         nvalid++;
         vdata = rx_data;
         vpos  = tpos;
      end
      if (idle_flag && !flag_prev) begin
         rise_pos = tpos;
         nrise++;
      end
      if (!idle_flag && flag_prev) fall_pos = tpos;
      flag_prev = idle_flag;
      tpos++;
   endtask

   task automatic step_rst(input logic v);
      sw_rst = 1'b1;
      step(v);
      sw_rst = 1'b0;
   endtask

   task automatic idle_line(input int n);
      for (int i = 0; i < n; i++) step(1'b1);
   endtask

   task automatic send_frame(input logic [7:0] b, input bit flip, output int fs);
      int n;
      int h;
      n  = int'(baud_div);
      h  = n / 2;
      fs = tpos;
      for (int p = 0; p < 10 * n; p++) begin
         int bi;
         int ph;
         logic v;
         bi = p / n;
         ph = p % n;
         if (bi == 0)      v = 1'b0;
         else if (bi == 9) v = 1'b1;
         else              v = b[bi-1];
         if (flip && bi >= 1 && bi <= 8 && ph == h) v = ~v;
         step(v);
      end
   endtask

   task automatic frame_check(input logic [7:0] b, input bit flip, input string dtag);
      int fs;
      int n0;
      int n;
      int h;
      n  = int'(baud_div);
      h  = n / 2;
      n0 = nvalid;
      send_frame(b, flip, fs);
      idle_line(2 * n);
      chk(nvalid == n0 + 1, "R5 strobe count", nvalid - n0, 1);
      chk(vdata == b, dtag, int'(vdata), int'(b));
      chk(vpos == fs + 9 * n + h + 3, "R5 latency", vpos - fs, 9 * n + h + 3);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int fs;
      int fs2;
      int n0;
      int r0;
      int n;
      int h;

      repeat (3) @(negedge clk);
      // R1: outputs while reset is held
      chk(rx_valid == 1'b0, "R1 valid", int'(rx_valid), 0);
      chk(idle_flag == 1'b0, "R1 flag", int'(idle_flag), 0);
      chk(rx_data == 8'h00, "R1 data", int'(rx_data), 0);
      rst_n = 1'b1;
      idle_line(4);
      chk(rx_valid == 1'b0 && idle_flag == 1'b0, "R1 after release",
          int'({rx_valid, idle_flag}), 0);

      // R2 / R3: filter thresholds for every select value
      baud_div = 12'd40;
      for (int s = 0; s < 4; s++) begin
         int len;
         len = 2 << s;
         glitch_sel = 2'(s);
         idle_line(2);
         n0 = nvalid;
         for (int i = 0; i < len - 1; i++) step(1'b0);
         idle_line(12 * 40);
         chk(nvalid == n0, "R2 short pulse", nvalid - n0, 0);
         for (int i = 0; i < len; i++) step(1'b0);
         idle_line(12 * 40);
         chk(nvalid == n0, "R3 vote rejects", nvalid - n0, 0);
         frame_check(8'hA5 ^ 8'(s), 1'b0, "R3 frame after abandon");
      end

      // R4: every byte value at an even bit length
      glitch_sel = 2'd0;
      baud_div = 12'd8;
      for (int b = 0; b < 256; b++) frame_check(8'(b), 1'b0, "R4 data");
      // R4: odd bit length
      baud_div = 12'd9;
      for (int b = 0; b < 256; b += 3) frame_check(8'(b), 1'b0, "R4 data odd");

      // R6: one corrupted centre sample per data bit
      baud_div = 12'd40;
      glitch_sel = 2'd1;
      frame_check(8'h3C, 1'b1, "R6 vote");
      frame_check(8'hC3, 1'b1, "R6 vote");
      frame_check(8'h00, 1'b1, "R6 vote");

      // R7 / R8 / R9: idle-line monitoring
      glitch_sel = 2'd0;
      baud_div = 12'd16;
      n = 16;
      h = 8;
      idle_mode = 1'b1;
      idle_line(2);
      send_frame(8'h96, 1'b0, fs);
      idle_line(11 * n);
      chk(rise_pos == fs + 19 * n + h + 3, "R7 flag timing", rise_pos - fs, 19 * n + h + 3);
      chk(idle_flag == 1'b1, "R7 flag set", int'(idle_flag), 1);
      chk(vdata == 8'h96, "R4 data in idle mode", int'(vdata), 8'h96);
      r0 = nrise;
      n0 = nvalid;
      send_frame(8'h69, 1'b0, fs);
      chk(fall_pos == fs + h + 3, "R9 clear timing", fall_pos - fs, h + 3);
      idle_line(9 * n);
      send_frame(8'h0F, 1'b0, fs2);
      chk(nrise == r0, "R8 nine ones no flag", nrise - r0, 0);
      chk(idle_flag == 1'b0, "R8 flag low", int'(idle_flag), 0);
      chk(nvalid == n0 + 2, "R8 both received", nvalid - n0, 2);
      chk(vdata == 8'h0F, "R8 second data", int'(vdata), 8'h0F);
      idle_line(11 * n);
      chk(rise_pos == fs2 + 19 * n + h + 3, "R7 flag timing", rise_pos - fs2, 19 * n + h + 3);
      chk(nrise == r0 + 1, "R7 one rise", nrise - r0, 1);

      // R10: soft reset clears the flag
      step_rst(1'b1);
      chk(idle_flag == 1'b0, "R10 flag cleared", int'(idle_flag), 0);

      // R9: normal mode never raises the flag
      idle_mode = 1'b0;
      r0 = nrise;
      frame_check(8'h5A, 1'b0, "R9 data");
      idle_line(12 * n);
      chk(nrise == r0 && idle_flag == 1'b0, "R9 no flag in normal mode", nrise - r0, 0);

      // R10: abort mid-frame, remaining bits are high
      n0 = nvalid;
      for (int p = 0; p < 5 * n; p++) step(1'b0);
      step_rst(1'b1);
      idle_line(12 * n);
      chk(nvalid == n0, "R10 aborted frame", nvalid - n0, 0);
      frame_check(8'h81, 1'b0, "R10 frame after abort");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule